// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Array

This block is a square grid of multiply-accumulate cells, `SIZE` cells on a side, that multiplies a stream of input rows (matrix A) by a resident weight matrix (matrix B). Weights are shifted into the grid from the top edge, one row per clock, while the load enable is high. When the enable drops, every cell keeps its weight and uses it as its multiplier operand.

Activations enter each row at its highest-numbered column and step one column toward column 0 on every clock, whatever the state of the load enable. Each cell multiplies the activation at its input in the same cycle, adds the partial sum arriving from above, and registers the total for the cell below. The top row adds to an externally supplied vector of initial sums. The bottom row drives the result vector.

The surrounding logic skews the activation rows going in and de-skews the results coming out. Tiling and operand storage also sit outside the block.

Top module: `sa_grid`

## Requirements
- R1: The asynchronous active-low reset clears every stored weight, activation and partial sum to zero. During reset and right after it, `res_o` reads zero, and a product run without a weight load gives all-zero results.
- R2: While `load_i` is high, each cell captures the weight held by the cell above it on every clock, and row 0 captures `b_i`. After `SIZE` load cycles in which `b_i` carries weight rows `SIZE-1` down to `0`, row `r` holds weight row `r`.
- R3: While `load_i` is low, the stored weights do not change, and any value on `b_i` has no effect on later results.
- R4: Element `r` of `a_i` enters row `r` at column `SIZE-1`. Each cell registers its activation and passes it one column toward column 0 per clock.
- R5: A cell multiplies the activation present at its input in that same cycle. Weight element (r,c) and a one-cycle pulse on `a_i[r]` in cycle t therefore appear on `res_o[c]` during cycle t+2·SIZE−1−c−r, and not one cycle earlier or later.
- R6: Each cell registers sum_in + A·W and feeds it to the sum input of the cell below.
- R7: `sum_i[c]` is the sum operand of the cell in row 0, column c. A value driven there in cycle t reaches `res_o[c]` during cycle t+SIZE.
- R8: Operands are signed 16-bit two's complement. Each product is sign-extended to 32 bits, and accumulation wraps modulo 2^32 with no saturation.
- R9: Let input row i drive `a_i[r] = X[i][r]` in cycle t0+i+r, with `sum_i[c]` equal to B[i][c] in cycle t0+i+SIZE−1−c. Then `res_o[c]` equals Σr X[i][r]·W[r][c] + B[i][c] during cycle t0+i+2·SIZE−1−c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Weight shift enable |
| a_i | input | SIZE×16 | Activation element per row (signed) |
| b_i | input | SIZE×16 | Weight element per column, into row 0 (signed) |
| sum_i | input | SIZE×32 | Initial sum per column for row 0 |
| res_o | output | SIZE×32 | Bottom-row partial sums per column |

## Verification
A corrupt weight in cell (r,c) shows up only in column c of the result. It appears on every output row that has a nonzero X[i][r], and the first such result arrives 2·SIZE−1−c cycles after that row's skewed start. A misrouted or mistimed activation shifts a contribution to another output row or cycle. The single-pulse test catches such a shift at the exact cycle. A stuck partial-sum register corrupts its column within at most SIZE cycles, and the zero-activation sum-pass check in the cell flags it on the next edge.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int OP_W  = 16;
  localparam int ACC_W = 32;
  typedef logic signed [OP_W-1:0]  op_t;
  typedef logic signed [ACC_W-1:0] acc_t;
endpackage

// File: rtl/sa_cell.sv
module sa_cell
  import sa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  op_t  w_in_i,
  input  op_t  a_in_i,
  input  acc_t sum_in_i,
  output op_t  w_o,
  output op_t  a_o,
  output acc_t sum_o
);
  op_t  w_q, a_q;
  acc_t sum_q, prod;

  // operand A taken unregistered; product sign-extended, wraps
  assign prod = acc_t'(a_in_i) * acc_t'(w_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= '0;
      a_q   <= '0;
      sum_q <= '0;
    end else begin
      a_q   <= a_in_i;
      sum_q <= sum_in_i + prod;
      if (load_i) w_q <= w_in_i;
    end
  end

  assign w_o   = w_q;
  assign a_o   = a_q;
  assign sum_o = sum_q;

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_w_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && load_i |=> w_o == $past(w_in_i));
  p_w_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !load_i |=> $stable(w_o));
  p_a_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |=> a_o == $past(a_in_i));
  p_sum_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && (a_in_i == '0 || w_o == '0) |=> sum_o == $past(sum_in_i));
endmodule

// File: rtl/sa_row.sv
module sa_row
  import sa_pkg::*;
#(
  parameter int SIZE = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [OP_W-1:0]            a_i,
  input  logic [SIZE-1:0][OP_W-1:0]  w_in_i,
  input  logic [SIZE-1:0][ACC_W-1:0] sum_in_i,
  output logic [SIZE-1:0][OP_W-1:0]  w_o,
  output logic [SIZE-1:0][ACC_W-1:0] sum_o
);
  // a_chain[SIZE] is the row entry, a_chain[0] leaves column 0
  logic [SIZE:0][OP_W-1:0] a_chain;
  assign a_chain[SIZE] = a_i;

  for (genvar c = 0; c < SIZE; c++) begin : g_col
    sa_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .w_in_i   (w_in_i[c]),
      .a_in_i   (a_chain[c+1]),
      .sum_in_i (sum_in_i[c]),
      .w_o      (w_o[c]),
      .a_o      (a_chain[c]),
      .sum_o    (sum_o[c])
    );
  end

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_a_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |=> a_chain[0] == $past(a_chain[1]));
endmodule

// File: rtl/sa_grid.sv
module sa_grid
  import sa_pkg::*;
#(
  parameter int SIZE = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [SIZE-1:0][OP_W-1:0]  a_i,
  input  logic [SIZE-1:0][OP_W-1:0]  b_i,
  input  logic [SIZE-1:0][ACC_W-1:0] sum_i,
  output logic [SIZE-1:0][ACC_W-1:0] res_o
);
  // index r feeds row r; index SIZE is the bottom edge
  logic [SIZE:0][SIZE-1:0][OP_W-1:0]  w_chain;
  logic [SIZE:0][SIZE-1:0][ACC_W-1:0] s_chain;

  assign w_chain[0] = b_i;
  assign s_chain[0] = sum_i;
  assign res_o      = s_chain[SIZE];

  for (genvar r = 0; r < SIZE; r++) begin : g_row
    sa_row #(.SIZE(SIZE)) u_row (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .a_i      (a_i[r]),
      .w_in_i   (w_chain[r]),
      .sum_in_i (s_chain[r]),
      .w_o      (w_chain[r+1]),
      .sum_o    (s_chain[r+1])
    );
  end

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_tail_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !load_i |=> $stable(w_chain[SIZE]));
  p_tail_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && load_i |=> w_chain[SIZE] == $past(w_chain[SIZE-1]));
  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> res_o == '0);
endmodule

// File: tb/sa_grid_tb_top.sv
`timescale 1ns/1ps
module sa_grid_tb_top;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [S-1:0][15:0] a_drv = '0;
  logic [S-1:0][15:0] b_drv = '0;
  logic [S-1:0][31:0] s_drv = '0;
  logic [S-1:0][31:0] res;

  int checks = 0;
  int errors = 0;
  int wm [S][S];
  int xm [S][S];
  int bm [S][S];

  always #2 clk = ~clk;

  sa_grid #(.SIZE(S)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .load_i (load),
    .a_i (a_drv), .b_i (b_drv), .sum_i (s_drv), .res_o (res)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      load = 1'b0; a_drv = '0; b_drv = '0; s_drv = '0;
    end
  endtask

  // R2: b_i carries row S-1 first, row 0 last
  task automatic load_weights();
    for (int k = 0; k < S; k++) begin
      @(negedge clk);
      load = 1'b1;
      for (int c = 0; c < S; c++) b_drv[c] = 16'(wm[S-1-k][c]);
    end
    @(negedge clk);
    load = 1'b0; b_drv = '0;
  endtask

  // R9: skewed rows in, de-skewed result check per element
  task automatic run_product(string req);
    int y [S][S];
    for (int i = 0; i < S; i++)
      for (int c = 0; c < S; c++) begin
        y[i][c] = bm[i][c];
        for (int r = 0; r < S; r++) y[i][c] += xm[i][r] * wm[r][c];
      end
    for (int n = 0; n < 3*S; n++) begin
      @(negedge clk);
      for (int c = 0; c < S; c++) begin
        int i = n - (2*S-1) + c;
        if (i >= 0 && i < S) check(req, int'($signed(res[c])), y[i][c]);
      end
      for (int r = 0; r < S; r++)
        a_drv[r] = (n-r >= 0 && n-r < S) ? 16'(xm[n-r][r]) : 16'd0;
      for (int c = 0; c < S; c++) begin
        int i2 = n - (S-1-c);
        s_drv[c] = (i2 >= 0 && i2 < S) ? 32'(bm[i2][c]) : 32'd0;
      end
    end
    idle(S);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < S; c++) check("R1 reset", int'(res[c]), 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_basic();
    for (int r = 0; r < S; r++)
      for (int c = 0; c < S; c++) begin
        wm[r][c] = (r*S + c + 1) * ((c % 2 == 1) ? -1 : 1);
        xm[r][c] = 3*r - 2*c + 5;
        bm[r][c] = 0;
      end
    load_weights();
    run_product("R2 R6 R9 product");
  endtask

  task automatic t_hold_bias();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      load = 1'b0;
      for (int c = 0; c < S; c++) b_drv[c] = 16'(1234 + 97*k + c);
    end
    @(negedge clk);
    b_drv = '0;
    for (int r = 0; r < S; r++)
      for (int c = 0; c < S; c++) begin
        xm[r][c] = (r == c) ? -7 : r + c;
        bm[r][c] = 1000*r - 300*c + 11;
      end
    run_product("R3 R7 hold+bias");
  endtask

  // R4 R5: single weight, single pulse, exact arrival cycle
  task automatic t_single(int rr, int cc);
    int t_hit = 2*S - 1 - cc - rr;
    for (int r = 0; r < S; r++)
      for (int c = 0; c < S; c++) wm[r][c] = (r == rr && c == cc) ? 1 : 0;
    load_weights();
    for (int n = 0; n <= 2*S + 1; n++) begin
      @(negedge clk);
      if (n == t_hit - 1) check("R4 R5 early", int'(res[cc]), 0);
      if (n == t_hit) begin
        check("R4 R5 arrival", int'(res[cc]), 77);
        for (int c = 0; c < S; c++)
          if (c != cc) check("R4 other column", int'(res[c]), 0);
      end
      if (n == t_hit + 1) check("R4 R5 late", int'(res[cc]), 0);
      a_drv = '0;
      if (n == 0) a_drv[rr] = 16'd77;
    end
    idle(S);
  endtask

  task automatic t_wrap();
    for (int r = 0; r < S; r++)
      for (int c = 0; c < S; c++) begin
        wm[r][c] = -32768;
        xm[r][c] = (c == 0) ? 32767 : -32768;
        bm[r][c] = (r == 1) ? 32'h7fff_ffff : 0;
      end
    load_weights();
    run_product("R8 wrap");
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < S; c++) check("R1 mid reset", int'(res[c]), 0);
    rst_n = 1'b1;
    for (int r = 0; r < S; r++)
      for (int c = 0; c < S; c++) begin
        xm[r][c] = 9 + r;
        wm[r][c] = 0;
        bm[r][c] = 0;
      end
    run_product("R1 weights cleared");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold_bias();
    t_single(1, 2);
    t_single(S-1, 0);
    t_wrap();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule